// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns a single asynchronous serial input into parallel characters. A sample tick enables it, and that tick runs at a fixed multiple of the bit rate. While idle, the line rests high. A falling edge arms the receiver. The receiver accepts the start only when the line has stayed low for half a bit. It then takes one sample at the centre of each bit and assembles the data bits, least significant first. After the data it checks an optional parity bit and one or two stop bits.

Every clean transition inside a character pulls the bit-phase counter back to mid-bit. The receiver therefore keeps up with a transmitter whose rate is somewhat off nominal. A line held low for longer than a whole character raises a break flag.

A finished character moves into a holding register, which frees the shift path for the next character. The character is stored with its parity and framing flags. A data-valid flag and an interrupt request are raised with it. The data width, parity mode and stop count are set through configuration inputs and are captured when each start bit is accepted.

Top module: `sio_receiver`

## Requirements
- R1: All receive timing advances only on cycles with `sample_tick` high. The parameter `OVERSAMPLE` must be 8 or 16, and with the tick held low a complete frame on the line produces no character.
- R2: After reset, `rx_valid`, `rx_perr`, `rx_ferr`, `rx_overrun`, `rx_break` and `rx_irq` are all low.
- R3: A low pulse shorter than half a bit time is discarded. The receiver returns to idle with no character delivered, and a normal frame that follows is received correctly.
- R4: Data bits are taken least significant first. `cfg_data_bits` holds the count as a plain binary number from 5 to 9 (below 5 acts as 5, above `DATA_MAX` acts as `DATA_MAX`). `rx_data` is right-justified with the unused upper bits zero.
- R5: With `cfg_parity_en` = 1, one parity bit follows the data. If `cfg_parity_odd` = 1, the data ones plus the parity bit must total an odd count; if it is 0, they must total an even count. A mismatch sets `rx_perr` for that character.
- R6: One stop bit is used, or two when `cfg_two_stop` = 1. Each stop sample must be high, and any low stop sample sets `rx_ferr`. The character is still delivered.
- R7: If the line stays low for more than one character time (OVERSAMPLE × (start + data + parity + stop) ticks), `rx_break` is set. It stays set until a read.
- R8: Every line transition inside a frame re-centres the sampling point. A frame whose bits change on every bit is received correctly at bit periods 12.5 % shorter or longer than nominal.
- R9: A completed character is loaded into the holding register and sets `rx_valid`. The held data stays unchanged while the next character is shifted in.
- R10: If a character completes while `rx_valid` is high and no read occurs in that cycle, `rx_overrun` is set and the older character is kept.
- R11: A `rd_strobe` pulse clears `rx_valid`, `rx_overrun` and `rx_break` on the next clock edge.
- R12: `rx_irq` is high whenever `rx_valid` or `rx_break` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle enable at OVERSAMPLE × bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_data_bits | input | 4 | Data bits per character, 5..9 |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rd_strobe | input | 1 | Read pulse that consumes the held character |
| rx_data | output | DATA_MAX | Held character, right-justified |
| rx_valid | output | 1 | Holding register contains an unread character |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |
| rx_overrun | output | 1 | A character was lost while the register was full |
| rx_break | output | 1 | Break condition seen since the last read |
| rx_irq | output | 1 | Interrupt request |

## Verification
`rx_valid` and the stored flags rise one clock after the centre sample of the last stop bit. That sample comes about half a bit into the stop bit, once the synchroniser and tick quantisation have added their delay. For this reason every frame is followed by three idle bit periods before the outputs are sampled on a falling edge. A read takes effect at the next rising edge, so its result is checked on the falling edge that follows the strobe. The break flag is due one tick after the low stretch exceeds a character time. The bench holds the line low for well over twice that long before it looks.

// File: rtl/sio_pkg.sv
package sio_pkg;

   localparam int CFG_W = 4;
   localparam int MIN_BITS = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP,
      ST_DRAIN
   } rx_state_e;

   // Clamp a requested data-bit count into MIN_BITS..max_bits
   function automatic logic [CFG_W-1:0] clamp_bits(input logic [CFG_W-1:0] req,
                                                   input logic [CFG_W-1:0] max_bits);
      if (req < CFG_W'(MIN_BITS)) return CFG_W'(MIN_BITS);
      if (req > max_bits)         return max_bits;
      return req;
   endfunction

endpackage

// File: rtl/sio_line_sync.sv
module sio_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx_in,
   output logic line_lvl,
   output logic line_edge
);

   logic [STAGES-1:0] chain;
   logic              prev_lvl;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sio_line_sync: STAGES must be at least 2");
      end
   endgenerate

   // metastability chain, idle level is high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], rx_in};
   end

   assign line_lvl = chain[STAGES-1];

   // level seen at the previous sample tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_lvl <= 1'b1;
      else if (tick) prev_lvl <= line_lvl;
   end

   assign line_edge = tick & (line_lvl ^ prev_lvl);

endmodule

// File: rtl/sio_bit_engine.sv
module sio_bit_engine
   import sio_pkg::*;
#(
   parameter int OVS = 16,
   parameter int DW  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             line_lvl,
   input  logic             line_edge,
   input  logic [CFG_W-1:0] cfg_bits,
   input  logic             cfg_par_en,
   input  logic             cfg_par_odd,
   input  logic             cfg_two_stop,
   output logic             frame_done,
   output logic [DW-1:0]    frame_data,
   output logic             frame_perr,
   output logic             frame_ferr
);

   localparam int CW   = $clog2(OVS);
   localparam int HALF = OVS / 2;
   localparam int NBW  = $clog2(DW + 1);
   localparam logic [CW-1:0] RELOAD_FULL = CW'(OVS - 1);
   localparam logic [CW-1:0] RELOAD_HALF = CW'(HALF - 2);

   rx_state_e        state;
   logic [CW-1:0]    cnt;
   logic [CFG_W-1:0] bit_idx;
   logic [CFG_W-1:0] nb_l;
   logic             pen_l, podd_l, two_l;
   logic             stop_idx;
   logic [DW-1:0]    sr;
   logic             par_acc;
   logic             perr_r, ferr_r, done_r;
   logic [NBW-1:0]   shift_amt;
   logic             in_frame;

   assign in_frame = (state == ST_DATA) || (state == ST_PARITY) || (state == ST_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         nb_l     <= CFG_W'(DW);
         pen_l    <= 1'b0;
         podd_l   <= 1'b0;
         two_l    <= 1'b0;
         stop_idx <= 1'b0;
         sr       <= '0;
         par_acc  <= 1'b0;
         perr_r   <= 1'b0;
         ferr_r   <= 1'b0;
         done_r   <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (tick) begin
            if (state == ST_IDLE) begin
               if (!line_lvl) begin
                  state  <= ST_START;
                  cnt    <= RELOAD_HALF;
                  nb_l   <= clamp_bits(cfg_bits, CFG_W'(DW));
                  pen_l  <= cfg_par_en;
                  podd_l <= cfg_par_odd;
                  two_l  <= cfg_two_stop;
               end
            end else if (state == ST_START) begin
               if (line_lvl) begin
                  state <= ST_IDLE;            // spurious low pulse
               end else if (cnt == '0) begin
                  state    <= ST_DATA;
                  cnt      <= RELOAD_FULL;
                  bit_idx  <= '0;
                  par_acc  <= 1'b0;
                  perr_r   <= 1'b0;
                  ferr_r   <= 1'b0;
                  stop_idx <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end else if (in_frame) begin
               if (line_edge) begin
                  cnt <= RELOAD_HALF;          // re-centre on a transition
               end else if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else begin
                  cnt <= RELOAD_FULL;
                  if (state == ST_DATA) begin
                     sr      <= {line_lvl, sr[DW-1:1]};
                     par_acc <= par_acc ^ line_lvl;
                     bit_idx <= bit_idx + 1'b1;
                     if (bit_idx == nb_l - 1'b1)
                        state <= pen_l ? ST_PARITY : ST_STOP;
                  end else if (state == ST_PARITY) begin
                     perr_r <= par_acc ^ line_lvl ^ podd_l;
                     state  <= ST_STOP;
                  end else begin
                     ferr_r <= ferr_r | ~line_lvl;
                     if (two_l && !stop_idx) begin
                        stop_idx <= 1'b1;
                     end else begin
                        done_r <= 1'b1;
                        state  <= line_lvl ? ST_IDLE : ST_DRAIN;
                     end
                  end
               end
            end else if (state == ST_DRAIN) begin
               if (line_lvl) state <= ST_IDLE;
            end else begin
               state <= ST_IDLE;
            end
         end
      end
   end

   assign shift_amt  = NBW'(DW) - NBW'(nb_l);
   assign frame_data = sr >> shift_amt;
   assign frame_done = done_r;
   assign frame_perr = perr_r;
   assign frame_ferr = ferr_r;

endmodule

// File: rtl/sio_break_det.sv
module sio_break_det
   import sio_pkg::*;
#(
   parameter int OVS = 16,
   parameter int DW  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             line_lvl,
   input  logic [CFG_W-1:0] cfg_bits,
   input  logic             cfg_par_en,
   input  logic             cfg_two_stop,
   output logic             break_hit
);

   localparam int BW = $clog2(OVS * (DW + 4) + 2);

   logic [BW-1:0]    low_cnt;
   logic [BW-1:0]    char_ticks;
   logic [CFG_W-1:0] nb;

   assign nb         = clamp_bits(cfg_bits, CFG_W'(DW));
   assign char_ticks = BW'(OVS) * (BW'(2) + BW'(nb) + BW'(cfg_par_en) + BW'(cfg_two_stop));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt   <= '0;
         break_hit <= 1'b0;
      end else begin
         break_hit <= 1'b0;
         if (tick) begin
            if (line_lvl) begin
               low_cnt <= '0;
            end else begin
               if (low_cnt == char_ticks) break_hit <= 1'b1;
               if (low_cnt != '1)         low_cnt   <= low_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sio_hold_reg.sv
module sio_hold_reg #(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          load_perr,
   input  logic          load_ferr,
   input  logic          break_hit,
   input  logic          rd,
   output logic [DW-1:0] data_q,
   output logic          valid_q,
   output logic          perr_q,
   output logic          ferr_q,
   output logic          ovr_q,
   output logic          brk_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
         ovr_q   <= 1'b0;
         brk_q   <= 1'b0;
      end else begin
         if (rd) begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
            brk_q   <= 1'b0;
         end
         if (load) begin
            if (valid_q && !rd) begin
               ovr_q <= 1'b1;
            end else begin
               data_q  <= load_data;
               perr_q  <= load_perr;
               ferr_q  <= load_ferr;
               valid_q <= 1'b1;
            end
         end
         if (break_hit) brk_q <= 1'b1;
      end
   end

endmodule

// File: rtl/sio_receiver.sv
module sio_receiver
   import sio_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_MAX    = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_tick,
   input  logic                rx_line,
   input  logic [3:0]          cfg_data_bits,
   input  logic                cfg_parity_en,
   input  logic                cfg_parity_odd,
   input  logic                cfg_two_stop,
   input  logic                rd_strobe,
   output logic [DATA_MAX-1:0] rx_data,
   output logic                rx_valid,
   output logic                rx_perr,
   output logic                rx_ferr,
   output logic                rx_overrun,
   output logic                rx_break,
   output logic                rx_irq
);

   generate
      if (OVERSAMPLE != 8 && OVERSAMPLE != 16) begin : g_bad_ovs
         $error("sio_receiver: OVERSAMPLE must be 8 or 16");
      end
      if (DATA_MAX < MIN_BITS || DATA_MAX > 9) begin : g_bad_width
         $error("sio_receiver: DATA_MAX must lie in 5..9");
      end
   endgenerate

   logic                line_lvl;
   logic                line_edge;
   logic                frame_done;
   logic [DATA_MAX-1:0] frame_data;
   logic                frame_perr;
   logic                frame_ferr;
   logic                break_hit;

   sio_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sample_tick),
      .rx_in     (rx_line),
      .line_lvl  (line_lvl),
      .line_edge (line_edge)
   );

   sio_bit_engine #(.OVS(OVERSAMPLE), .DW(DATA_MAX)) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (sample_tick),
      .line_lvl     (line_lvl),
      .line_edge    (line_edge),
      .cfg_bits     (cfg_data_bits),
      .cfg_par_en   (cfg_parity_en),
      .cfg_par_odd  (cfg_parity_odd),
      .cfg_two_stop (cfg_two_stop),
      .frame_done   (frame_done),
      .frame_data   (frame_data),
      .frame_perr   (frame_perr),
      .frame_ferr   (frame_ferr)
   );

   sio_break_det #(.OVS(OVERSAMPLE), .DW(DATA_MAX)) u_break (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (sample_tick),
      .line_lvl     (line_lvl),
      .cfg_bits     (cfg_data_bits),
      .cfg_par_en   (cfg_parity_en),
      .cfg_two_stop (cfg_two_stop),
      .break_hit    (break_hit)
   );

   sio_hold_reg #(.DW(DATA_MAX)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_done),
      .load_data (frame_data),
      .load_perr (frame_perr),
      .load_ferr (frame_ferr),
      .break_hit (break_hit),
      .rd        (rd_strobe),
      .data_q    (rx_data),
      .valid_q   (rx_valid),
      .perr_q    (rx_perr),
      .ferr_q    (rx_ferr),
      .ovr_q     (rx_overrun),
      .brk_q     (rx_break)
   );

   assign rx_irq = rx_valid | rx_break;

endmodule

// File: rtl/sio_receiver_chk.sv
module sio_receiver_chk #(
   parameter int DW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_strobe,
   input logic [DW-1:0] rx_data,
   input logic          rx_valid,
   input logic          rx_overrun,
   input logic          rx_break,
   input logic          rx_irq,
   input logic          frame_done,
   input logic          line_lvl
);

   // R9: held character does not change while unread
   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rd_strobe |=> $stable(rx_data));

   // R9: valid only rises after the engine finished a frame
   assert_valid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(frame_done));

   // R10: completion into a full, unread register flags overrun
   assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && frame_done && !rd_strobe |=> rx_overrun);

   // R11: a read with no new completion empties the register
   assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && !frame_done |=> !rx_valid && !rx_overrun);

   // R7: break only flagged while the line was low
   assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_break) |-> $past(!line_lvl));

   // R12: interrupt accompanies new data
   assert_irq_with_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> rx_irq);

endmodule

bind sio_receiver sio_receiver_chk #(.DW(DATA_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_strobe  (rd_strobe),
   .rx_data    (rx_data),
   .rx_valid   (rx_valid),
   .rx_overrun (rx_overrun),
   .rx_break   (rx_break),
   .rx_irq     (rx_irq),
   .frame_done (frame_done),
   .line_lvl   (line_lvl)
);

// File: tb/sio_receiver_tb.sv
module sio_receiver_tb;

   localparam int CLK_PERIOD = 10;
   localparam int BIT_CLKS   = 32;   // 16 ticks, tick every other clock
   localparam int NV         = 10;

   // {data[27:19], nbits[18:15], pen[14], podd[13], two[12], badpar[11], badstop[10], bitclks[9:0]}
   localparam logic [27:0] VEC [NV] = '{
      {9'h0A5, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd32},  // R4 8 bits
      {9'h013, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd32},  // R4 5 bits
      {9'h1A7, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd32},  // R4 R5 9 bits even
      {9'h05B, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd32},  // R5 odd parity
      {9'h0C3, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd32},  // R6 two stops
      {9'h06E, 4'd8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'd32},  // R5 bad parity
      {9'h03F, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd32},  // R6 low stop
      {9'h055, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd28},  // R8 fast sender
      {9'h055, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd36},  // R8 slow sender
      {9'h155, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd30}   // R8 R5 R6 mixed
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b0;
   logic       tick_en = 1'b1;
   logic       rx_line = 1'b1;
   logic [3:0] cfg_data_bits = 4'd8;
   logic       cfg_parity_en = 1'b0;
   logic       cfg_parity_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [8:0] rx_data;
   logic       rx_valid, rx_perr, rx_ferr, rx_overrun, rx_break, rx_irq;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;
   int  cycles = 0;

   sio_receiver #(.OVERSAMPLE(16), .DATA_MAX(9), .SYNC_STAGES(2)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .sample_tick    (sample_tick),
      .rx_line        (rx_line),
      .cfg_data_bits  (cfg_data_bits),
      .cfg_parity_en  (cfg_parity_en),
      .cfg_parity_odd (cfg_parity_odd),
      .cfg_two_stop   (cfg_two_stop),
      .rd_strobe      (rd_strobe),
      .rx_data        (rx_data),
      .rx_valid       (rx_valid),
      .rx_perr        (rx_perr),
      .rx_ferr        (rx_ferr),
      .rx_overrun     (rx_overrun),
      .rx_break       (rx_break),
      .rx_irq         (rx_irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         sample_tick = tick_en ? ~sample_tick : 1'b0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int n);
      rx_line = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic idle(input int n);
      rx_line = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [8:0] d, input int nb, input bit pen, input bit podd,
                             input bit two, input bit badpar, input bit badstop, input int bt);
      logic [8:0] m;
      logic       p;
      m = d & ((9'h1 << nb) - 9'h1);
      p = (^m) ^ podd ^ badpar;
      drive(1'b0, bt);
      for (int i = 0; i < nb; i++) drive(d[i], bt);
      if (pen) drive(p, bt);
      drive(~badstop, bt);
      if (two) drive(1'b1, bt);
      rx_line = 1'b1;
   endtask

   task automatic do_read();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic set_cfg(input int nb, input bit pen, input bit podd, input bit two);
      cfg_data_bits  = 4'(nb);
      cfg_parity_en  = pen;
      cfg_parity_odd = podd;
      cfg_two_stop   = two;
   endtask

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R2 reset state
      check(rx_valid == 1'b0,   "R2 valid after reset",   rx_valid, 0);
      check(rx_irq == 1'b0,     "R2 irq after reset",     rx_irq, 0);
      check(rx_break == 1'b0,   "R2 break after reset",   rx_break, 0);
      check(rx_overrun == 1'b0, "R2 overrun after reset", rx_overrun, 0);
      check(rx_perr == 1'b0 && rx_ferr == 1'b0, "R2 error flags after reset",
            {rx_perr, rx_ferr}, 0);
      rst_n = 1'b1;
      idle(4 * BIT_CLKS);

      // table-driven frames: R4 R5 R6 R8 R9 R12
      for (int i = 0; i < NV; i++) begin
         logic [8:0] d;
         logic [8:0] exp_d;
         int         nb, bt;
         bit         pen, podd, two, bpar, bstop;
         d     = VEC[i][27:19];
         nb    = int'(VEC[i][18:15]);
         pen   = VEC[i][14];
         podd  = VEC[i][13];
         two   = VEC[i][12];
         bpar  = VEC[i][11];
         bstop = VEC[i][10];
         bt    = int'(VEC[i][9:0]);
         exp_d = d & ((9'h1 << nb) - 9'h1);
         set_cfg(nb, pen, podd, two);
         send_frame(d, nb, pen, podd, two, bpar, bstop, bt);
         idle(3 * BIT_CLKS);
         check(rx_valid == 1'b1, $sformatf("R9 vector %0d valid", i), rx_valid, 1);
         check(rx_data == exp_d, $sformatf("R4/R8 vector %0d data", i), rx_data, exp_d);
         check(rx_perr == bpar, $sformatf("R5 vector %0d parity flag", i), rx_perr, bpar);
         check(rx_ferr == bstop, $sformatf("R6 vector %0d framing flag", i), rx_ferr, bstop);
         check(rx_irq == 1'b1, $sformatf("R12 vector %0d irq", i), rx_irq, 1);
         do_read();
         check(rx_valid == 1'b0, $sformatf("R11 vector %0d read clears", i), rx_valid, 0);
         idle(BIT_CLKS);
      end

      // R3 spurious start pulse
      set_cfg(8, 1'b0, 1'b0, 1'b0);
      drive(1'b0, 6);
      idle(12 * BIT_CLKS);
      check(rx_valid == 1'b0, "R3 short pulse ignored", rx_valid, 0);
      check(rx_irq == 1'b0, "R3 no irq after short pulse", rx_irq, 0);
      send_frame(9'h03C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, BIT_CLKS);
      idle(3 * BIT_CLKS);
      check(rx_valid == 1'b1 && rx_data == 9'h03C, "R3 frame after pulse",
            rx_data, 9'h03C);
      do_read();

      // R1 no tick, no reception
      tick_en = 1'b0;
      idle(4);
      send_frame(9'h081, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, BIT_CLKS);
      idle(3 * BIT_CLKS);
      check(rx_valid == 1'b0, "R1 frame without tick", rx_valid, 0);
      tick_en = 1'b1;
      idle(2 * BIT_CLKS);

      // R10 overrun keeps first character
      send_frame(9'h011, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, BIT_CLKS);
      idle(2 * BIT_CLKS);
      send_frame(9'h022, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, BIT_CLKS);
      idle(3 * BIT_CLKS);
      check(rx_overrun == 1'b1, "R10 overrun flag", rx_overrun, 1);
      check(rx_data == 9'h011, "R10 older character kept", rx_data, 9'h011);
      do_read();
      check(rx_overrun == 1'b0 && rx_valid == 1'b0, "R11 read clears overrun",
            {rx_overrun, rx_valid}, 0);

      // R7 break
      drive(1'b0, 25 * BIT_CLKS);
      check(rx_break == 1'b1, "R7 break flag", rx_break, 1);
      check(rx_irq == 1'b1, "R12 irq on break", rx_irq, 1);
      idle(3 * BIT_CLKS);
      check(rx_valid == 1'b1 && rx_ferr == 1'b1 && rx_data == 9'h000,
            "R6 break character framing", {rx_valid, rx_ferr, rx_data}, 12'h600);
      do_read();
      check(rx_break == 1'b0 && rx_valid == 1'b0, "R11 read clears break",
            {rx_break, rx_valid}, 0);
      idle(4 * BIT_CLKS);
      check(rx_valid == 1'b0, "R7 no extra character after break", rx_valid, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule